// File: doc/BRIEF.md
# Crosspoint Routing Configuration Store

This block is the first-rank programming store of an 8-output, 8-input crosspoint switch. It holds one configuration word of eight 5-bit groups, one group per switch output. Each group carries an output-enable bit, a reserved bit and a 3-bit code that picks the input driving that output. The word is presented in full to a second-rank stage, which copies it into the switch on its own strobe.

The word can be loaded in two ways, selected by a mode input. In serial mode the whole word is shifted in one bit per falling edge of an external shift clock, and the top bit of the word is driven on a chain output so that several stores can be connected end to end. In parallel mode a 3-bit address picks one group, and that group is rewritten from a 4-bit data bus on a falling edge of the same clock. The reserved bit of the group is forced to 1. An active-low chip enable freezes the word in both modes.

The block runs on one system clock. The external shift clock and every control and data pin are passed through a two-flop synchroniser, and a falling-edge detector on the synchronised shift clock times each load. The word itself has no reset.

Top module: `xpt_cfg_reg`

## Requirements
- R1: Group g (0..7) occupies word_o bits [5g+4:5g]. Bit 5g+4 is the output enable, bit 5g+3 is the reserved bit and bits 5g+2..5g are the input select, most significant bit first.
- R2: When mode_i is 0, a falling edge of sclk_i performs a serial shift and addr_i and pdata_i are ignored. When mode_i is 1, it performs a parallel group write and sdata_i is ignored.
- R3: In serial mode, each falling edge of sclk_i moves the word one place toward bit 39 and loads sdata_i into bit 0.
- R4: After 40 serial shifts, the first bit sent sits in bit 39 (the enable of group 7) and the last bit sent sits in bit 0 (select bit 0 of group 0).
- R5: sdo_o always equals word_o bit 39, in both modes. A bit shifted in therefore shows on sdo_o after exactly 40 falling edges, and not after 39.
- R6: In parallel mode, a falling edge of sclk_i writes group addr_i as follows: enable = pdata_i[3], select = pdata_i[2:0], reserved = 1. All other groups are left unchanged.
- R7: In parallel mode, one write occurs per low-going transition of sclk_i. Changes on pdata_i while sclk_i stays low have no effect.
- R8: While en_ni is 1, word_o does not change in either mode.
- R9: Without a falling edge on sclk_i, word_o does not change, whatever the other inputs do.
- R10: word_o reflects a load no later than 4 system clock cycles after the falling edge of sclk_i.
- R11: rst_ni resets only the synchronisers. word_o keeps its contents through a reset taken while sclk_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the synchronisers |
| sclk_i | input | 1 | External shift / write clock; loads on its falling edge |
| sdata_i | input | 1 | Serial data in |
| mode_i | input | 1 | 0 = serial load, 1 = parallel group write |
| en_ni | input | 1 | Active-low chip enable; 1 freezes the word |
| addr_i | input | 3 | Group address for parallel writes |
| pdata_i | input | 4 | Parallel data: [3] enable, [2:0] input select |
| sdo_o | output | 1 | Chain output, top bit of the word |
| word_o | output | 40 | Full configuration word to the second rank |

## Verification
Two serial loads use unrelated bit patterns. One of them has every reserved bit cleared, so that the reserved bits forced by later parallel writes stand out. The word patterns also show any reversal of group or bit order. A single 1 walked through a word of zeros separates a chain of the correct length from one that is one stage short or one stage long. Parallel writes to addresses 0, 3 and 7 catch wrong decoding at both ends of the range. Changing the data bus while the clock is held low, freezing the block with the chip enable, idling with a stable clock and resetting mid-run each test a case where the word must not change.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  localparam int unsigned NUM_OUT_DEF = 8;
  localparam int unsigned SEL_W_DEF   = 3;

  typedef enum logic {
    LOAD_SERIAL   = 1'b0,
    LOAD_PARALLEL = 1'b1
  } load_mode_e;
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/xpt_fall_det.sv
module xpt_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  // idle level of the shift clock is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/xpt_cfg_store.sv
module xpt_cfg_store
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned NUM_OUT = NUM_OUT_DEF,
  parameter int unsigned SEL_W   = SEL_W_DEF,
  localparam int unsigned GRP_W  = SEL_W + 2,
  localparam int unsigned WORD_W = NUM_OUT * GRP_W,
  localparam int unsigned ADDR_W = $clog2(NUM_OUT),
  localparam int unsigned PD_W   = SEL_W + 1
) (
  input  logic              clk_i,
  input  logic              fall_i,
  input  logic              hold_i,
  input  load_mode_e        mode_i,
  input  logic              sdi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PD_W-1:0]   pdata_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] shifted;
  logic [GRP_W-1:0]  par_grp;
  logic              load;

  assign shifted = {word_o[WORD_W-2:0], sdi_i};
  assign par_grp = {pdata_i[SEL_W], 1'b1, pdata_i[SEL_W-1:0]};
  assign load    = fall_i & ~hold_i;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_grp
    logic [GRP_W-1:0] grp_q;

    // no reset: contents are defined by the first full load
    always_ff @(posedge clk_i) begin
      if (load) begin
        if (mode_i == LOAD_SERIAL)
          grp_q <= shifted[g*GRP_W +: GRP_W];
        else if (addr_i == ADDR_W'(g))
          grp_q <= par_grp;
      end
    end

    assign word_o[g*GRP_W +: GRP_W] = grp_q;
  end
endmodule

// File: rtl/xpt_cfg_reg.sv
module xpt_cfg_reg
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned NUM_OUT = NUM_OUT_DEF,
  parameter int unsigned SEL_W   = SEL_W_DEF,
  localparam int unsigned GRP_W  = SEL_W + 2,
  localparam int unsigned WORD_W = NUM_OUT * GRP_W,
  localparam int unsigned ADDR_W = $clog2(NUM_OUT),
  localparam int unsigned PD_W   = SEL_W + 1,
  localparam int unsigned SYNC_W = 4 + ADDR_W + PD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              mode_i,
  input  logic              en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PD_W-1:0]   pdata_i,
  output logic              sdo_o,
  output logic [WORD_W-1:0] word_o
);
  // idle: clock high, chip disabled
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 2'b00, 1'b1, {(ADDR_W+PD_W){1'b0}}};

  logic [SYNC_W-1:0] raw, syn;
  logic              sclk_s, sdi_s, hold_s, sclk_fall;
  load_mode_e        mode_s;
  logic [ADDR_W-1:0] addr_s;
  logic [PD_W-1:0]   pdata_s;

  assign raw = {sclk_i, sdata_i, mode_i, en_ni, addr_i, pdata_i};

  xpt_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign sclk_s  = syn[SYNC_W-1];
  assign sdi_s   = syn[SYNC_W-2];
  assign mode_s  = load_mode_e'(syn[SYNC_W-3]);
  assign hold_s  = syn[SYNC_W-4];
  assign addr_s  = syn[PD_W +: ADDR_W];
  assign pdata_s = syn[PD_W-1:0];

  xpt_fall_det u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sclk_s),
    .fall_o(sclk_fall)
  );

  xpt_cfg_store #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_store (
    .clk_i  (clk_i),
    .fall_i (sclk_fall),
    .hold_i (hold_s),
    .mode_i (mode_s),
    .sdi_i  (sdi_s),
    .addr_i (addr_s),
    .pdata_i(pdata_s),
    .word_o (word_o)
  );

  assign sdo_o = word_o[WORD_W-1];
endmodule

// File: rtl/xpt_cfg_chk.sv
module xpt_cfg_chk #(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned SEL_W   = 3,
  localparam int unsigned GRP_W  = SEL_W + 2,
  localparam int unsigned WORD_W = NUM_OUT * GRP_W,
  localparam int unsigned ADDR_W = $clog2(NUM_OUT),
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fall_i,
  input logic              hold_i,
  input logic              mode_i,
  input logic              sdi_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] word_o
);
  // the word is defined only once a full serial load has passed
  logic [CNT_W-1:0] shifts_q;
  logic             armed;

  assign armed = (shifts_q == CNT_W'(WORD_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shifts_q <= '0;
    else if (fall_i && !hold_i && !mode_i && !armed) shifts_q <= shifts_q + 1'b1;
  end

  assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !fall_i) |=> $stable(word_o));

  assert_hold_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && fall_i && hold_i) |=> $stable(word_o));

  assert_serial_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && fall_i && !hold_i && !mode_i) |=>
      (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0]) && word_o[0] == $past(sdi_i)));

  assert_rsv_forced_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !hold_i && mode_i) |=> word_o[$past(addr_i)*GRP_W + GRP_W - 2]);
endmodule

bind xpt_cfg_reg xpt_cfg_chk #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .fall_i(sclk_fall),
  .hold_i(hold_s),
  .mode_i(mode_s),
  .sdi_i (sdi_s),
  .addr_i(addr_s),
  .word_o(word_o)
);

// File: tb/sim_xpt_cfg_reg.sv
module sim_xpt_cfg_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 40;

  logic clk = 0, rst_ni = 0;
  logic sclk = 1, sdata = 0, mode = 0, en_n = 0;
  logic [2:0] addr = '0;
  logic [3:0] pdata = '0;
  logic sdo;
  logic [W-1:0] word;

  int checks = 0, errors = 0;
  logic [W-1:0] model;

  typedef struct {
    string        tag;
    logic         full;
    logic [W-1:0] word;
    logic         sdo;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_cfg_reg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .mode_i(mode),
    .en_ni(en_n), .addr_i(addr), .pdata_i(pdata), .sdo_o(sdo), .word_o(word)
  );

  // monitor: pops expectations and compares at the driver's sample point
  initial begin
    exp_t e;
    forever begin
      wait (q.size() != 0);
      e = q.pop_front();
      checks++;
      if (e.full && word !== e.word) begin
        errors++;
        $display("FAIL %s word actual %h expected %h", e.tag, word, e.word);
      end else if (sdo !== e.sdo) begin
        errors++;
        $display("FAIL %s sdo actual %b expected %b", e.tag, sdo, e.sdo);
      end
    end
  end

  task automatic expect_word(string tag);
    exp_t e;
    e.tag = tag; e.full = 1'b1; e.word = model; e.sdo = model[W-1];
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic expect_sdo(string tag, logic s);
    exp_t e;
    e.tag = tag; e.full = 1'b0; e.word = '0; e.sdo = s;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic pulse();
    @(negedge clk); sclk = 0;
    repeat (4) @(negedge clk);
    sclk = 1;
    repeat (4) @(negedge clk);
  endtask

  // serial shift of one bit; junk on the parallel bus must be ignored (R2)
  task automatic shift_bit(logic b);
    sdata = b; addr = $urandom; pdata = $urandom;
    pulse();
    if (!en_n) model = {model[W-2:0], b};
  endtask

  // R4: first bit sent = bit 39
  task automatic load_word(logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  // R6 layout from R1: enable 5g+4, reserved 5g+3, select 5g+2..5g
  task automatic par_write(int g, logic en, logic [2:0] sel);
    addr = 3'(g); pdata = {en, sel}; sdata = $urandom;
    pulse();
    if (!en_n) begin
      model[5*g+4] = en;
      model[5*g+3] = 1'b1;
      model[5*g +: 3] = sel;
    end
  endtask

  function automatic logic [W-1:0] rsv_mask();
    logic [W-1:0] m = '0;
    for (int g = 0; g < 8; g++) m[5*g+3] = 1'b1;
    return m;
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] wb;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);

    mode = 0; en_n = 0;
    load_word(40'hA53C960FE1);
    expect_word("R1 R4 serial load A");
    wb = 40'h5AC369F01E & ~rsv_mask();
    load_word(wb);
    expect_word("R3 R4 serial load B");

    shift_bit(1'b1);
    expect_sdo("R5 chain shows next bit", wb[W-2]);

    // R5: walking one reaches sdo after exactly 40 shifts
    load_word('0);
    shift_bit(1'b1);
    for (int i = 0; i < 38; i++) shift_bit(1'b0);
    expect_sdo("R5 after 39 shifts", 1'b0);
    shift_bit(1'b0);
    expect_sdo("R5 after 40 shifts", 1'b1);
    expect_word("R3 walking one word");

    // parallel writes
    load_word(wb);
    mode = 1;
    par_write(3, 1'b1, 3'b010);
    expect_word("R6 addr 3 reserved forced");
    par_write(0, 1'b0, 3'b111);
    expect_word("R6 addr 0");
    par_write(7, 1'b0, 3'b101);
    expect_word("R5 R6 addr 7 enable low in parallel mode");
    par_write(7, 1'b1, 3'b000);
    expect_word("R5 R2 addr 7 enable high in parallel mode");

    // R7: data change while clock stays low
    addr = 3'd5; pdata = 4'b1011;
    @(negedge clk); sclk = 0;
    repeat (5) @(negedge clk);
    pdata = 4'b0100;
    repeat (5) @(negedge clk);
    sclk = 1;
    repeat (4) @(negedge clk);
    model[5*5+4] = 1'b1; model[5*5+3] = 1'b1; model[5*5 +: 3] = 3'b011;
    expect_word("R7 one write per low clock");

    // R8: chip disabled in both modes
    en_n = 1;
    par_write(2, 1'b1, 3'b110);
    expect_word("R8 parallel frozen");
    mode = 0;
    for (int i = 0; i < 5; i++) shift_bit(i[0]);
    expect_word("R8 serial frozen");
    en_n = 0;

    // R9: no falling edge, toggling everything else
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sdata = ~sdata; addr = addr + 1; pdata = pdata + 3; mode = ~mode;
    end
    mode = 0;
    repeat (4) @(negedge clk);
    expect_word("R9 idle stable");

    // R10: update within 4 system clocks of the edge
    sdata = 1'b1;
    @(negedge clk); sclk = 0;
    repeat (4) @(negedge clk);
    model = {model[W-2:0], 1'b1};
    expect_word("R10 latency");
    sclk = 1;
    repeat (4) @(negedge clk);

    // R11: reset keeps the word
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    expect_word("R11 word kept through reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule